// File: doc/BRIEF.md
# Video Power Domain Sequencer

This block steps a video subsystem power domain between its off and on states in a fixed order. A request on `start_on` lifts the domain power-down, wakes the memory banks one group at a time, waits for things to settle, and then takes the logic out of isolation and reset before its clocks are enabled. A request on `start_off` runs the mirror image. Isolation goes on first and the memories are put to sleep group by group. The domain is then powered down, the clocks are gated and the resets are asserted.

Every wait is counted on `us_tick`, a one-cycle pulse that the surrounding chip produces once per microsecond. There is a fixed gap after each memory step and a longer settle time around the memory phase. The two memory control sets are a vector of 2-bit groups and a vector of single bits. The groups are stepped first, in ascending order, and then the single bits, in ascending order. While a sequence runs, `busy` is high. At completion, `done` pulses for one cycle.

Top module: `vid_pwr_seq`

## Requirements
- R1: After reset, `dom_pd`=1, `iso_en`=1, every bit of `mem_pair_pd` and `mem_single_pd` is 1, `sub_rst_n` is all 0, `clk_en`=0, `busy`=0 and `done`=0. The block is in the powered-off state.
- R2: A power-on request accepted in the off state first clears `dom_pd`. It then drives each 2-bit group of `mem_pair_pd` to 00, taking group 0 (bits 1:0) first and going upward. After that it drives each bit of `mem_single_pd` to 0, bit 0 first.
- R3: Consecutive memory steps in either direction are separated by at least GAP_US (default 5) `us_tick` pulses. Only one group or bit changes per step.
- R4: In both directions, at least SETTLE_US (default 20) `us_tick` pulses pass between the last memory step and the next output change.
- R5: The power-on tail holds `sub_rst_n` at all 0 while it clears `iso_en`. It then drives `sub_rst_n` to all 1, and then sets `clk_en`. These are three separate cycles in that order.
- R6: A power-off request accepted in the on state first sets `iso_en`. At least SETTLE_US ticks later it drives each group to 11 in ascending order, and then each single bit to 1 in ascending order.
- R7: The power-off tail sets `dom_pd`, then clears `clk_en`, then drives `sub_rst_n` to all 0. These are separate cycles in that order.
- R8: `busy` is high from the cycle after an accepted request until completion. `done` is high for exactly one cycle, in the first cycle with `busy` low.
- R9: `start_on` or `start_off` asserted while `busy` is high has no effect, and the running sequence completes unchanged.
- R10: In the off state `start_off` alone is ignored. In the on state `start_on` alone is ignored. Neither raises `busy` nor changes any output.
- R11: In any one cycle, at most one of these output fields changes: `dom_pd`, `iso_en`, `mem_pair_pd`, `mem_single_pd`, `sub_rst_n`, `clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start_on | input | 1 | Power-on request |
| start_off | input | 1 | Power-off request |
| dom_pd | output | 1 | Domain power-down, 1 = powered down |
| iso_en | output | 1 | Isolation enable, 1 = isolated |
| mem_pair_pd | output | 2*NUM_PAIRS | 2-bit memory power-down groups, 11 = down, 00 = up |
| mem_single_pd | output | NUM_SINGLES | Single-bit memory power-down controls, 1 = down |
| sub_rst_n | output | NUM_RESETS | Subsystem resets, active low |
| clk_en | output | 1 | Subsystem clock enable |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The bench records every output change with the number of ticks that came before it. It compares this log against the expected order and the minimum spacing, so a design that opened the group ladder on the wrong bit or skipped a group shows up as a kind or index mismatch. A timer that expired one tick early shows up as a spacing shortfall, most visibly at the settle wait that straddles the last memory step. Requests of both kinds are injected in the middle of each sequence. A design that restarted or reversed would produce an extra or out-of-order change. Repeating the power-on with a tick on every cycle exposes any off-by-one in the tick counting, and the idle mismatched-request tests catch a design that accepts a request for the state it is already in.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the video power domain sequencer.
// Assumes: a single clock domain; the state encoding is private to the top.
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF,       // resting, domain powered down
        S_ON,        // resting, domain powered up
        S_UP_DOM,    // lift domain power-down
        S_MEM_STEP,  // switch one memory group or bit
        S_MEM_WAIT,  // gap after a memory step
        S_SETTLE,    // long wait after the last memory step
        S_UP_RSTA,   // hold subsystem resets
        S_UP_ISO,    // drop isolation
        S_UP_RSTR,   // release subsystem resets
        S_UP_CLK,    // enable clocks, finish power-on
        S_DN_ISO,    // raise isolation
        S_DN_ISOW,   // settle after isolation
        S_DN_DOM,    // set domain power-down
        S_DN_CLK,    // gate clocks
        S_DN_RST     // assert resets, finish power-off
    } seq_state_t;

endpackage

// File: rtl/pwr_wait_timer.sv
// Microsecond wait timer.
// Loads a length in ticks, counts down once per us_tick and reports expiry
// while the remaining count is zero. A load takes priority over a tick.
// Assumes: len is at least 1, so expiry is never seen in the cycle after a load.
module pwr_wait_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] len,
    input  logic          tick,
    output logic          expired
);

    logic [TW-1:0] remain;

    // Countdown register: reload on request, otherwise decrement on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= len;
        end else if (tick && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/pwr_mem_ladder.sv
// Memory power-down ladder.
// Holds the 2-bit group controls and the single-bit controls. A step drives
// one entry to the power-down level (all ones) or to the power-up level
// (all zeros). Step indices 0..NUM_PAIRS-1 select the groups, and the indices
// after them select the single bits.
// Assumes: the sequencer issues at most one step per cycle.
module pwr_mem_ladder #(
    parameter int NUM_PAIRS   = 8,
    parameter int NUM_SINGLES = 8,
    parameter int IW          = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_en,
    input  logic [IW-1:0]          step_idx,
    input  logic                   power_down,
    output logic [2*NUM_PAIRS-1:0] pair_pd,
    output logic [NUM_SINGLES-1:0] single_pd
);

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic [1:0] grp_q;
        // One 2-bit group: reset to down, rewritten when its index is stepped.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_q <= 2'b11;
            end else if (step_en && (step_idx == IW'(g))) begin
                grp_q <= {2{power_down}};
            end
        end
        assign pair_pd[2*g +: 2] = grp_q;
    end

    for (genvar s = 0; s < NUM_SINGLES; s++) begin : g_single
        logic bit_q;
        // One single-bit control: reset to down, rewritten when stepped.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b1;
            end else if (step_en && (step_idx == IW'(NUM_PAIRS + s))) begin
                bit_q <= power_down;
            end
        end
        assign single_pd[s] = bit_q;
    end

endmodule

// File: rtl/vid_pwr_seq.sv
// Video power domain on/off sequencer (top).
// Power-on: clear domain power-down, wake the memory groups and then the
// single bits with a gap after each, settle, hold the resets, drop isolation,
// release the resets, enable the clocks.
// Power-off: raise isolation, settle, put the memories to sleep in the same
// order, settle, set domain power-down, gate the clocks, assert the resets.
// Requests are honoured only in the matching resting state.
// Assumes: us_tick is a single-cycle pulse; GAP_US and SETTLE_US are >= 1.
module vid_pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int NUM_PAIRS   = 8,
    parameter int NUM_SINGLES = 8,
    parameter int NUM_RESETS  = 4,
    parameter int GAP_US      = 5,
    parameter int SETTLE_US   = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   us_tick,
    input  logic                   start_on,
    input  logic                   start_off,
    output logic                   dom_pd,
    output logic                   iso_en,
    output logic [2*NUM_PAIRS-1:0] mem_pair_pd,
    output logic [NUM_SINGLES-1:0] mem_single_pd,
    output logic [NUM_RESETS-1:0]  sub_rst_n,
    output logic                   clk_en,
    output logic                   busy,
    output logic                   done
);

    localparam int NUM_STEPS = NUM_PAIRS + NUM_SINGLES;
    localparam int IW        = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
    localparam int MAX_WAIT  = (GAP_US > SETTLE_US) ? GAP_US : SETTLE_US;
    localparam int TW        = $clog2(MAX_WAIT + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_STEPS - 1);

    seq_state_t      state;
    logic [IW-1:0]   idx;
    logic            going_down;
    logic            tmr_load;
    logic [TW-1:0]   tmr_len;
    logic            tmr_done;
    logic            step_en;
    logic            last_step;

    assign step_en   = (state == S_MEM_STEP);
    assign last_step = (idx == LAST_IDX);

    // Timer control: short gap after a memory step, long settle elsewhere.
    always_comb begin
        tmr_load = step_en || (state == S_DN_ISO) ||
                   ((state == S_MEM_WAIT) && tmr_done && last_step);
        tmr_len  = step_en ? TW'(GAP_US) : TW'(SETTLE_US);
    end

    pwr_wait_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .tick    (us_tick),
        .expired (tmr_done)
    );

    pwr_mem_ladder #(
        .NUM_PAIRS   (NUM_PAIRS),
        .NUM_SINGLES (NUM_SINGLES),
        .IW          (IW)
    ) u_ladder (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .step_idx   (idx),
        .power_down (going_down),
        .pair_pd    (mem_pair_pd),
        .single_pd  (mem_single_pd)
    );

    // Sequencer: walks the fixed order and drives the domain-level controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_OFF;
            idx        <= '0;
            going_down <= 1'b0;
            dom_pd     <= 1'b1;
            iso_en     <= 1'b1;
            sub_rst_n  <= '0;
            clk_en     <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_OFF: begin
                    if (start_on) begin
                        going_down <= 1'b0;
                        state      <= S_UP_DOM;
                    end
                end
                S_ON: begin
                    if (start_off) begin
                        going_down <= 1'b1;
                        state      <= S_DN_ISO;
                    end
                end
                S_UP_DOM: begin
                    dom_pd <= 1'b0;
                    idx    <= '0;
                    state  <= S_MEM_STEP;
                end
                S_MEM_STEP: begin
                    state <= S_MEM_WAIT;
                end
                S_MEM_WAIT: begin
                    if (tmr_done) begin
                        if (last_step) begin
                            state <= S_SETTLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_MEM_STEP;
                        end
                    end
                end
                S_SETTLE: begin
                    if (tmr_done) begin
                        state <= going_down ? S_DN_DOM : S_UP_RSTA;
                    end
                end
                S_UP_RSTA: begin
                    sub_rst_n <= '0;
                    state     <= S_UP_ISO;
                end
                S_UP_ISO: begin
                    iso_en <= 1'b0;
                    state  <= S_UP_RSTR;
                end
                S_UP_RSTR: begin
                    sub_rst_n <= '1;
                    state     <= S_UP_CLK;
                end
                S_UP_CLK: begin
                    clk_en <= 1'b1;
                    done   <= 1'b1;
                    state  <= S_ON;
                end
                S_DN_ISO: begin
                    iso_en <= 1'b1;
                    state  <= S_DN_ISOW;
                end
                S_DN_ISOW: begin
                    if (tmr_done) begin
                        idx   <= '0;
                        state <= S_MEM_STEP;
                    end
                end
                S_DN_DOM: begin
                    dom_pd <= 1'b1;
                    state  <= S_DN_CLK;
                end
                S_DN_CLK: begin
                    clk_en <= 1'b0;
                    state  <= S_DN_RST;
                end
                S_DN_RST: begin
                    sub_rst_n <= '0;
                    done      <= 1'b1;
                    state     <= S_OFF;
                end
                default: begin
                    state <= S_OFF;
                end
            endcase
        end
    end

    // Busy covers every state except the two resting ones.
    assign busy = (state != S_OFF) && (state != S_ON);

endmodule

// File: rtl/vid_pwr_seq_chk.sv
// Assertion checker for vid_pwr_seq, attached by bind.
// Checks the ordering rules and the handshake behaviour seen at the ports.
module vid_pwr_seq_chk #(
    parameter int NUM_PAIRS   = 8,
    parameter int NUM_SINGLES = 8,
    parameter int NUM_RESETS  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_on,
    input logic                   start_off,
    input logic                   dom_pd,
    input logic                   iso_en,
    input logic [2*NUM_PAIRS-1:0] mem_pair_pd,
    input logic [NUM_SINGLES-1:0] mem_single_pd,
    input logic [NUM_RESETS-1:0]  sub_rst_n,
    input logic                   clk_en,
    input logic                   busy,
    input logic                   done
);

    a_r11_one_field: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!$stable(dom_pd), !$stable(iso_en), !$stable(mem_pair_pd),
                    !$stable(mem_single_pd), !$stable(sub_rst_n), !$stable(clk_en)}) <= 1);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    a_r2_dom_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_pd) |-> (iso_en && !clk_en && (&mem_pair_pd) && (&mem_single_pd)));

    a_r5_iso_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> ((sub_rst_n == '0) && !clk_en && !dom_pd));

    a_r5_clk_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> (!iso_en && (&sub_rst_n)));

    a_r7_dom_late: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_pd) |-> (iso_en && clk_en && (&mem_pair_pd) && (&mem_single_pd)));

    a_r10_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clk_en && start_off && !start_on) |=> !busy);

    a_r10_on_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && clk_en && start_on && !start_off) |=> !busy);

endmodule

bind vid_pwr_seq vid_pwr_seq_chk #(
    .NUM_PAIRS   (NUM_PAIRS),
    .NUM_SINGLES (NUM_SINGLES),
    .NUM_RESETS  (NUM_RESETS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_on      (start_on),
    .start_off     (start_off),
    .dom_pd        (dom_pd),
    .iso_en        (iso_en),
    .mem_pair_pd   (mem_pair_pd),
    .mem_single_pd (mem_single_pd),
    .sub_rst_n     (sub_rst_n),
    .clk_en        (clk_en),
    .busy          (busy),
    .done          (done)
);

// File: tb/test_vid_pwr_seq.sv
// Bench for vid_pwr_seq: logs every output change with the ticks that came
// before it, then walks a phase table to check the order and spacing.
module test_vid_pwr_seq;

    localparam int NP  = 8;
    localparam int NS  = 8;
    localparam int NR  = 4;
    localparam int GAP = 5;
    localparam int SET = 20;

    localparam int K_DOM = 0, K_PAIR = 1, K_SING = 2, K_ISO = 3, K_RST = 4, K_CLK = 5;

    typedef struct packed {
        logic       dn;
        logic [2:0] kind;
        logic [4:0] count;
        logic [5:0] first_gap;
        logic [5:0] next_gap;
        logic [1:0] val;
    } phase_t;

    localparam int NPH = 12;
    localparam phase_t PHASES [NPH] = '{
        '{1'b0, 3'(K_DOM),  5'd1,  6'd0,   6'd0,   2'd0},
        '{1'b0, 3'(K_PAIR), 5'(NP), 6'd0,  6'(GAP), 2'd0},
        '{1'b0, 3'(K_SING), 5'(NS), 6'(GAP), 6'(GAP), 2'd0},
        '{1'b0, 3'(K_ISO),  5'd1,  6'(SET), 6'd0,  2'd0},
        '{1'b0, 3'(K_RST),  5'd1,  6'd0,   6'd0,   2'd1},
        '{1'b0, 3'(K_CLK),  5'd1,  6'd0,   6'd0,   2'd1},
        '{1'b1, 3'(K_ISO),  5'd1,  6'd0,   6'd0,   2'd1},
        '{1'b1, 3'(K_PAIR), 5'(NP), 6'(SET), 6'(GAP), 2'd3},
        '{1'b1, 3'(K_SING), 5'(NS), 6'(GAP), 6'(GAP), 2'd1},
        '{1'b1, 3'(K_DOM),  5'd1,  6'(SET), 6'd0,  2'd1},
        '{1'b1, 3'(K_CLK),  5'd1,  6'd0,   6'd0,   2'd0},
        '{1'b1, 3'(K_RST),  5'd1,  6'd0,   6'd0,   2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          us_tick = 1'b0;
    logic          start_on = 1'b0;
    logic          start_off = 1'b0;
    logic          dom_pd, iso_en, clk_en, busy, done;
    logic [2*NP-1:0] mem_pair_pd;
    logic [NS-1:0]   mem_single_pd;
    logic [NR-1:0]   sub_rst_n;

    int checks = 0;
    int fails = 0;
    int tick_div = 3;
    bit finished = 0;

    vid_pwr_seq #(
        .NUM_PAIRS(NP), .NUM_SINGLES(NS), .NUM_RESETS(NR),
        .GAP_US(GAP), .SETTLE_US(SET)
    ) i_vid_pwr_seq (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .start_on(start_on), .start_off(start_off),
        .dom_pd(dom_pd), .iso_en(iso_en), .mem_pair_pd(mem_pair_pd),
        .mem_single_pd(mem_single_pd), .sub_rst_n(sub_rst_n),
        .clk_en(clk_en), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    // Tick source: one pulse every tick_div cycles, driven just after a rising edge.
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            #1;
            ph++;
            if (ph >= tick_div) begin
                ph = 0;
                us_tick = 1'b1;
            end else begin
                us_tick = 1'b0;
            end
        end
    end

    // Change log filled by the monitor.
    int ev_cnt = 0;
    int ev_kind [64];
    int ev_idx  [64];
    int ev_val  [64];
    int ev_gap  [64];
    int tick_acc = 0;
    int multi_chg = 0;
    int done_cycles = 0;
    int done_busy = 0;
    bit log_en = 0;

    logic            p_dom, p_iso, p_clk;
    logic [2*NP-1:0] p_pair;
    logic [NS-1:0]   p_sing;
    logic [NR-1:0]   p_rst;

    task automatic log_ev(input int k, input int i, input int v);
        if (ev_cnt < 64) begin
            ev_kind[ev_cnt] = k;
            ev_idx[ev_cnt]  = i;
            ev_val[ev_cnt]  = v;
            ev_gap[ev_cnt]  = tick_acc;
            ev_cnt++;
        end
    endtask

    // Monitor: sample outputs on the falling edge and log each field that changed.
    always @(negedge clk) begin
        int n;
        n = 0;
        if (rst_n && log_en) begin
            if (dom_pd != p_dom) begin log_ev(K_DOM, 0, int'(dom_pd)); n++; end
            if (iso_en != p_iso) begin log_ev(K_ISO, 0, int'(iso_en)); n++; end
            if (clk_en != p_clk) begin log_ev(K_CLK, 0, int'(clk_en)); n++; end
            if (sub_rst_n != p_rst) begin
                log_ev(K_RST, 0, (&sub_rst_n) ? 1 : ((sub_rst_n == '0) ? 0 : 2));
                n++;
            end
            for (int g = 0; g < NP; g++) begin
                if (mem_pair_pd[2*g +: 2] != p_pair[2*g +: 2]) begin
                    log_ev(K_PAIR, g, int'(mem_pair_pd[2*g +: 2]));
                    n++;
                end
            end
            for (int s = 0; s < NS; s++) begin
                if (mem_single_pd[s] != p_sing[s]) begin
                    log_ev(K_SING, s, int'(mem_single_pd[s]));
                    n++;
                end
            end
            if (n > 1) multi_chg++;
            if (done) begin
                done_cycles++;
                if (busy) done_busy++;
            end
        end
        if (n > 0) tick_acc = int'(us_tick);
        else tick_acc = tick_acc + int'(us_tick);
        p_dom = dom_pd; p_iso = iso_en; p_clk = clk_en;
        p_rst = sub_rst_n; p_pair = mem_pair_pd; p_sing = mem_single_pd;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        ev_cnt = 0;
        multi_chg = 0;
        done_cycles = 0;
        done_busy = 0;
        tick_acc = 0;
    endtask

    task automatic pulse(input bit on, input bit off);
        @(posedge clk);
        #1;
        start_on = on;
        start_off = off;
        @(posedge clk);
        #1;
        start_on = 1'b0;
        start_off = 1'b0;
    endtask

    // Walk the phase table for one direction and compare with the log.
    task automatic check_log(input bit dn);
        int e;
        string tag;
        e = 0;
        for (int p = 0; p < NPH; p++) begin
            if (PHASES[p].dn == dn) begin
                for (int k = 0; k < int'(PHASES[p].count); k++) begin
                    int mg;
                    case (int'(PHASES[p].kind))
                        K_DOM:  tag = dn ? "R7 domain down" : "R2 domain up";
                        K_PAIR: tag = dn ? "R6 group order" : "R2 group order";
                        K_SING: tag = dn ? "R6 single order" : "R2 single order";
                        K_ISO:  tag = dn ? "R6 isolation first" : "R5 isolation off";
                        K_RST:  tag = dn ? "R7 resets last" : "R5 reset release";
                        default: tag = dn ? "R7 clock gate" : "R5 clock enable";
                    endcase
                    mg = (k == 0) ? int'(PHASES[p].first_gap) : int'(PHASES[p].next_gap);
                    if (e < ev_cnt) begin
                        chk(ev_kind[e] == int'(PHASES[p].kind), {tag, " kind"},
                            ev_kind[e], int'(PHASES[p].kind));
                        chk(ev_idx[e] == k, {tag, " index"}, ev_idx[e], k);
                        chk(ev_val[e] == int'(PHASES[p].val), {tag, " value"},
                            ev_val[e], int'(PHASES[p].val));
                        chk(ev_gap[e] >= mg,
                            (mg == SET) ? "R4 settle spacing" : "R3 step spacing",
                            ev_gap[e], mg);
                    end else begin
                        chk(1'b0, {tag, " missing"}, ev_cnt, e + 1);
                    end
                    e++;
                end
            end
        end
        chk(ev_cnt == e, "R9 change count", ev_cnt, e);
        chk(multi_chg == 0, "R11 one field per cycle", multi_chg, 0);
        chk(done_cycles == 1, "R8 done width", done_cycles, 1);
        chk(done_busy == 0, "R8 done with busy low", done_busy, 0);
    endtask

    // Run one sequence, optionally injecting both requests mid-way.
    task automatic run_seq(input bit dn, input bit inject);
        int wait_c;
        clear_log();
        pulse(!dn, dn);
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy after request", int'(busy), 1);
        if (inject) begin
            repeat (30) @(posedge clk);
            pulse(1'b1, 1'b1);
            pulse(!dn, dn);
        end
        wait_c = 0;
        while (done_cycles == 0 && wait_c < 5000) begin
            @(negedge clk);
            wait_c++;
        end
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R8 busy low after done", int'(busy), 0);
        check_log(dn);
    endtask

    // Idle request of the wrong kind: nothing may move.
    task automatic idle_ignore(input bit on, input bit off, input string req);
        clear_log();
        pulse(on, off);
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, {req, " busy stays low"}, int'(busy), 0);
        chk(ev_cnt == 0, {req, " outputs unchanged"}, ev_cnt, 0);
        chk(done_cycles == 0, {req, " no done"}, done_cycles, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        log_en = 1;
        // R1: reset state
        chk(dom_pd == 1'b1, "R1 dom_pd", int'(dom_pd), 1);
        chk(iso_en == 1'b1, "R1 iso_en", int'(iso_en), 1);
        chk(&mem_pair_pd, "R1 groups down", int'(mem_pair_pd), (1 << (2*NP)) - 1);
        chk(&mem_single_pd, "R1 singles down", int'(mem_single_pd), (1 << NS) - 1);
        chk(sub_rst_n == '0, "R1 resets held", int'(sub_rst_n), 0);
        chk(clk_en == 1'b0, "R1 clk_en", int'(clk_en), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);

        // R10: power-off request while already off
        idle_ignore(1'b0, 1'b1, "R10 off in off");

        // R2..R5, R8, R9: power-on with injected requests, tick every 3 cycles
        run_seq(1'b0, 1'b1);

        // R10: power-on request while already on
        idle_ignore(1'b1, 1'b0, "R10 on in on");

        // R6, R7, R3, R4, R9: power-off with injected requests
        run_seq(1'b1, 1'b1);

        // Second power-on with a tick every cycle, no injection
        tick_div = 1;
        run_seq(1'b0, 1'b0);

        // Second power-off with a slow tick
        tick_div = 4;
        run_seq(1'b1, 1'b0);

        finish_run();
    end

endmodule